// File: doc/BRIEF.md
# Pin function select and output register bank

This block is the register file behind a general-purpose I/O unit of 54 pins. Each pin owns a 3-bit function code. Ten codes are packed into each 32-bit select word, and the pad ring and the alternate-function multiplexer both read these codes. The pin's output value sits in a latch. Software changes the latch only through write-one-to-set and write-one-to-clear words, so it never has to read, modify and write back a shared word. A read-only level word gives the synchronised state of each pad input.

Software reaches the block through a 32-bit word port with byte offsets. A write takes effect on the clock edge that samples it. A read returns its data one cycle after the request. The pins are split into two banks of 32. Bank 0 holds pins 0 to 31 and bank 1 holds pins 32 to 53. Each set, clear and level function has one word per bank.

Top module: `gpio_pinmux_regs`

## Requirements
- R1: After reset every function field is 0, every output latch is 0, `pad_oe` is all zeros and every select word reads 0.
- R2: Pin p's function code is held in select word p/10 (integer division), at byte offset 4*(p/10) counted from offset 0x00, in bits [3*(p%10)+2 : 3*(p%10)]. Writing the word stores the code and reading the word returns it.
- R3: `pad_oe[p]` is 1 only while pin p's code equals 1. Code 0 means GPIO input. Codes 4, 5, 6 and 7 select alternates 0 to 3, code 3 selects alternate 4 and code 2 selects alternate 5, and none of these six drives the pad from the latch.
- R4: A write to 0x1C (bank 0) or 0x20 (bank 1) sets the latch of every pin whose data bit is 1. Pins whose data bit is 0 are unchanged.
- R5: A write to 0x28 (bank 0) or 0x2C (bank 1) clears the latch of every pin whose data bit is 1. Pins whose data bit is 0 are unchanged.
- R6: A latch keeps its value while its pin is not in output mode. `pad_out` always shows the latch, and the latch reaches the pad again when code 1 is restored.
- R7: Reads of the four set and clear words return 0.
- R8: Select bits that belong to no pin read 0 and ignore writes. These are bits 31:30 of every select word and bits 31:12 of word 5, whose slots would hold pins 54 to 59.
- R9: The level words at 0x34 (pins 0 to 31 in bits 31:0) and 0x38 (pins 32 to 53 in bits 21:0, upper bits 0) return the pad inputs after a two-flop synchroniser. A read request sampled on the first or second rising edge after an input change returns the old level. A request sampled on the third edge returns the new level.
- R10: `pin_func[3*p+2 : 3*p]` always equals pin p's stored function code.
- R11: Offsets outside the select, set, clear and level words read 0. Writes to them change no field and no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write request, sampled on the rising edge |
| bus_rd_en | input | 1 | Read request, data on `bus_rdata` the next cycle |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 54 | Raw pad input levels |
| pad_out | output | 54 | Output latch value per pin |
| pad_oe | output | 54 | Output enable per pin |
| pin_func | output | 162 | Function code of each pin, 3 bits per pin |

## Verification
The hardest situation to reach is a latch that holds a value while its pin is parked in an alternate or input mode. No port ever shows that retained state while the enable is low. The bench sets a latch and moves the pin through every other code. It then restores output mode and checks that the old value comes straight back without any new set write. The synchroniser edge count is also hard to observe. The bench changes a pad input at the same moment as a run of back-to-back level reads, so that the three consecutive samples fall on the two stale edges and on the first fresh one.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;

   // Function codes; the numbering is fixed by the pad mux, not ordinal.
   typedef enum logic [2:0] {
      FUNC_INPUT  = 3'd0,
      FUNC_OUTPUT = 3'd1,
      FUNC_ALT5   = 3'd2,
      FUNC_ALT4   = 3'd3,
      FUNC_ALT0   = 3'd4,
      FUNC_ALT1   = 3'd5,
      FUNC_ALT2   = 3'd6,
      FUNC_ALT3   = 3'd7
   } func_code_e;

   localparam int FUNC_CODE_BITS = $bits(func_code_e);

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/gpio_fsel_store.sv
module gpio_fsel_store #(
   parameter int NUM_PINS  = 54,
   parameter int CODE_W    = 3,
   parameter int PPW       = 10,
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 6,
   parameter int IDX_W     = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [DATA_W-1:0]          rd_word,
   output logic [NUM_PINS*CODE_W-1:0] code_flat
);

   localparam int USED_BITS = PPW * CODE_W;

   logic [CODE_W-1:0] code_q [NUM_PINS];
   logic [DATA_W-1:0] word_view [NUM_WORDS];

   // One field register per existing pin; slots past NUM_PINS get no storage.
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int WORD  = p / PPW;
      localparam int SHIFT = (p % PPW) * CODE_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code_q[p] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(WORD)))
            code_q[p] <= wr_data[SHIFT +: CODE_W];
      end
   end

   if (USED_BITS < DATA_W) begin : g_pad_bits
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wr_data[DATA_W-1:USED_BITS];
   end

   always_comb begin
      for (int w = 0; w < NUM_WORDS; w++) word_view[w] = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         word_view[p / PPW][(p % PPW) * CODE_W +: CODE_W] = code_q[p];
         code_flat[p * CODE_W +: CODE_W] = code_q[p];
      end
   end

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (rd_idx == IDX_W'(w)) rd_word = word_view[w];
   end

   // R2: fields only move on a select write
   p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(code_flat));

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_PINS  = 54,
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_we,
   input  logic                clr_we,
   input  logic [BANK_W-1:0]   bank_idx,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [NUM_PINS-1:0] latch_q
);

   logic [NUM_PINS-1:0] set_mask;
   logic [NUM_PINS-1:0] clr_mask;
   logic [NUM_BANKS-1:0] bank_hit;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_hit[b] = (bank_idx == BANK_W'(b));
   end

   always_comb begin
      for (int p = 0; p < NUM_PINS; p++) begin
         set_mask[p] = set_we & bank_hit[p / DATA_W] & wr_data[p % DATA_W];
         clr_mask[p] = clr_we & bank_hit[p / DATA_W] & wr_data[p % DATA_W];
      end
   end

   // Clear has priority over set for the same pin.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q | set_mask) & ~clr_mask;
   end

   p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((latch_q & $past(set_mask)) == $past(set_mask)));

   p_clear_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((latch_q & $past(clr_mask)) == '0));

   p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(latch_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 54,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] level
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync needs at least two stages");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign level = stage_q[STAGES-1];

   if (STAGES == 2) begin : g_chk
      logic [1:0] warm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              warm_q <= '0;
         else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      end
      // R9: level trails the pad by exactly two edges
      p_sync_two_edges_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q >= 2'd2) |-> (level == $past(din, 2)));
   end

endmodule

// File: rtl/gpio_pinmux_regs.sv
module gpio_pinmux_regs
   import gpio_pinmux_pkg::*;
#(
   parameter int NUM_PINS      = 54,
   parameter int DATA_W        = 32,
   parameter int CODE_W        = 3,
   parameter int PINS_PER_WORD = 10,
   parameter int ADDR_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int SET_BASE      = 'h1C,
   parameter int CLR_BASE      = 'h28,
   parameter int LEV_BASE      = 'h34
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr_en,
   input  logic                       bus_rd_en,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [NUM_PINS-1:0]        pad_in,
   output logic [NUM_PINS-1:0]        pad_out,
   output logic [NUM_PINS-1:0]        pad_oe,
   output logic [NUM_PINS*CODE_W-1:0] pin_func
);

   localparam int NUM_BANKS = ceil_div(NUM_PINS, DATA_W);
   localparam int NUM_SEL   = ceil_div(NUM_PINS, PINS_PER_WORD);
   localparam int WA_W      = ADDR_W - 2;
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int SEL_W     = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
   localparam int SET_WORD  = SET_BASE / 4;
   localparam int CLR_WORD  = CLR_BASE / 4;
   localparam int LEV_WORD  = LEV_BASE / 4;

   // Elaboration-time checks on the parameter set
   if (CODE_W != FUNC_CODE_BITS) begin : g_bad_code
      $error("CODE_W must match the function code width");
   end
   if (PINS_PER_WORD * CODE_W > DATA_W) begin : g_bad_pack
      $error("select fields overflow a word");
   end
   if ((SET_BASE % 4) != 0 || (CLR_BASE % 4) != 0 || (LEV_BASE % 4) != 0) begin : g_bad_align
      $error("register bases must be word aligned");
   end
   if (NUM_SEL * 4 > SET_BASE || SET_BASE + NUM_BANKS * 4 > CLR_BASE ||
       CLR_BASE + NUM_BANKS * 4 > LEV_BASE) begin : g_bad_overlap
      $error("register windows overlap");
   end
   if (LEV_BASE + NUM_BANKS * 4 > (1 << ADDR_W)) begin : g_bad_span
      $error("address width too small");
   end

   // ---------------- decode ----------------
   logic [WA_W-1:0] wa;
   logic [WA_W-1:0] set_rel, clr_rel, lev_rel;
   logic            sel_hit, set_hit, clr_hit, lev_hit, any_hit;
   logic [BANK_W-1:0] wr_bank, lev_bank;
   logic [SEL_W-1:0]  sel_idx;

   assign wa      = bus_addr[ADDR_W-1:2];
   assign set_rel = wa - WA_W'(SET_WORD);
   assign clr_rel = wa - WA_W'(CLR_WORD);
   assign lev_rel = wa - WA_W'(LEV_WORD);

   assign sel_hit = (int'(wa) < NUM_SEL);
   assign set_hit = (int'(wa) >= SET_WORD) && (int'(wa) < SET_WORD + NUM_BANKS);
   assign clr_hit = (int'(wa) >= CLR_WORD) && (int'(wa) < CLR_WORD + NUM_BANKS);
   assign lev_hit = (int'(wa) >= LEV_WORD) && (int'(wa) < LEV_WORD + NUM_BANKS);
   assign any_hit = sel_hit | set_hit | clr_hit | lev_hit;

   assign wr_bank  = set_hit ? set_rel[BANK_W-1:0] : clr_rel[BANK_W-1:0];
   assign lev_bank = lev_rel[BANK_W-1:0];
   assign sel_idx  = wa[SEL_W-1:0];

   logic unused_addr;
   assign unused_addr = ^{bus_addr[1:0], set_rel, clr_rel, lev_rel, wa};

   // ---------------- storage ----------------
   logic [DATA_W-1:0]          sel_word;
   logic [NUM_PINS*CODE_W-1:0] code_flat;
   logic [NUM_PINS-1:0]        level;

   gpio_fsel_store #(
      .NUM_PINS (NUM_PINS), .CODE_W (CODE_W), .PPW (PINS_PER_WORD),
      .DATA_W (DATA_W), .NUM_WORDS (NUM_SEL), .IDX_W (SEL_W)
   ) u_fsel (
      .clk (clk), .rst_n (rst_n),
      .wr_en (bus_wr_en && sel_hit), .wr_idx (sel_idx), .wr_data (bus_wdata),
      .rd_idx (sel_idx), .rd_word (sel_word), .code_flat (code_flat)
   );

   gpio_out_latch #(
      .NUM_PINS (NUM_PINS), .DATA_W (DATA_W), .NUM_BANKS (NUM_BANKS), .BANK_W (BANK_W)
   ) u_latch (
      .clk (clk), .rst_n (rst_n),
      .set_we (bus_wr_en && set_hit), .clr_we (bus_wr_en && clr_hit),
      .bank_idx (wr_bank), .wr_data (bus_wdata), .latch_q (pad_out)
   );

   gpio_in_sync #(.W (NUM_PINS), .STAGES (SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .din (pad_in), .level (level)
   );

   // ---------------- pad controls ----------------
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
      assign pad_oe[p] = (func_code_e'(code_flat[p*CODE_W +: CODE_W]) == FUNC_OUTPUT);
   end
   assign pin_func = code_flat;

   // ---------------- read path ----------------
   logic [DATA_W-1:0] lev_words [NUM_BANKS];
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) lev_words[b] = '0;
      for (int p = 0; p < NUM_PINS; p++) lev_words[p / DATA_W][p % DATA_W] = level[p];
   end

   always_comb begin
      rd_mux = '0;
      if (sel_hit) rd_mux = sel_word;
      else if (lev_hit) begin
         for (int b = 0; b < NUM_BANKS; b++)
            if (lev_bank == BANK_W'(b)) rd_mux = lev_words[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_mux;
   end

   // ---------------- assertions ----------------
   p_oe_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_en |=> $stable(pad_oe));

   p_setclr_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && (set_hit || clr_hit)) |=> (bus_rdata == '0));

   p_sel_pad_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && sel_hit) |=> (bus_rdata[DATA_W-1:PINS_PER_WORD*CODE_W] == '0));

   p_unmapped_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && !any_hit) |=> (bus_rdata == '0));

endmodule

// File: tb/gpio_pinmux_regs_tb.sv
module gpio_pinmux_regs_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr_en = 1'b0;
   logic         bus_rd_en = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [53:0]  pad_in = '0;
   logic [53:0]  pad_out;
   logic [53:0]  pad_oe;
   logic [161:0] pin_func;

   int checks = 0;
   int errors = 0;
   logic [53:0] exp_out = '0;

   always #2 clk = ~clk;

   gpio_pinmux_regs u_dut (
      .clk (clk), .rst_n (rst_n), .bus_wr_en (bus_wr_en), .bus_rd_en (bus_rd_en),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe), .pin_func (pin_func)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 pad_oe", 64'(pad_oe), 64'h0);
      chk("R1 pad_out", 64'(pad_out), 64'h0);
      chk("R1 pin_func", 64'(|pin_func), 64'h0);
      rd(8'h00, d); chk("R1 word0", 64'(d), 64'h0);
      rd(8'h14, d); chk("R1 word5", 64'(d), 64'h0);
   endtask

   task automatic t_field_map();
      logic [31:0] d;
      wr(8'h04, 32'h5 << 9);   // pin 13 -> code 5
      rd(8'h04, d); chk("R2 word1 pin13", 64'(d), 64'h00000A00);
      chk("R10 pin13 code", 64'(pin_func[13*3 +: 3]), 64'd5);
      wr(8'h14, 32'h7 << 9);   // pin 53 -> code 7
      rd(8'h14, d); chk("R2 word5 pin53", 64'(d), 64'h00000E00);
      chk("R10 pin53 code", 64'(pin_func[53*3 +: 3]), 64'd7);
      wr(8'h00, 32'h0000_0018); // pin 1 -> code 3
      chk("R10 pin1 code", 64'(pin_func[1*3 +: 3]), 64'd3);
      chk("R10 pin0 code", 64'(pin_func[0 +: 3]), 64'd0);
   endtask

   task automatic t_unused_bits();
      logic [31:0] d;
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, d); chk("R8 word0 top bits", 64'(d), 64'h3FFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h14, d); chk("R8 word5 slots 54-59", 64'(d), 64'h0000_0FFF);
      wr(8'h00, 32'h0); wr(8'h14, 32'h0);
   endtask

   task automatic t_oe_codes();
      for (int c = 0; c < 8; c++) begin
         wr(8'h04, 32'(c) << 9);
         chk($sformatf("R3 pin13 oe code %0d", c), 64'(pad_oe[13]), 64'(c == 1));
         chk($sformatf("R3 others off code %0d", c), 64'(pad_oe & ~(54'd1 << 13)), 64'h0);
      end
      wr(8'h04, 32'h0);
   endtask

   task automatic t_set_clear();
      wr(8'h1C, 32'h0000_2001); exp_out[0] = 1'b1; exp_out[13] = 1'b1;
      chk("R4 set bank0", 64'(pad_out), 64'(exp_out));
      wr(8'h20, 32'h0020_0000); exp_out[53] = 1'b1;
      chk("R4 set bank1 pin53", 64'(pad_out), 64'(exp_out));
      wr(8'h1C, 32'h0);
      chk("R4 zero set no change", 64'(pad_out), 64'(exp_out));
      wr(8'h28, 32'h0000_2000); exp_out[13] = 1'b0;
      chk("R5 clear pin13 keep pin0", 64'(pad_out), 64'(exp_out));
      wr(8'h2C, 32'h0);
      chk("R5 zero clear no change", 64'(pad_out), 64'(exp_out));
      wr(8'h2C, 32'h0020_0000); exp_out[53] = 1'b0;
      chk("R5 clear bank1 pin53", 64'(pad_out), 64'(exp_out));
   endtask

   task automatic t_retention();
      // pin 0 latch is 1; walk its field through every non-output code
      for (int c = 7; c >= 0; c--) begin
         if (c != 1) begin
            wr(8'h00, 32'(c));
            chk($sformatf("R6 oe off code %0d", c), 64'(pad_oe[0]), 64'h0);
            chk($sformatf("R6 latch kept code %0d", c), 64'(pad_out[0]), 64'h1);
         end
      end
      wr(8'h00, 32'h1);
      chk("R6 oe restored", 64'(pad_oe[0]), 64'h1);
      chk("R6 value restored", 64'(pad_out[0]), 64'h1);
      wr(8'h00, 32'h0);
   endtask

   task automatic t_setclr_read();
      logic [31:0] d;
      rd(8'h1C, d); chk("R7 read set0", 64'(d), 64'h0);
      rd(8'h20, d); chk("R7 read set1", 64'(d), 64'h0);
      rd(8'h28, d); chk("R7 read clr0", 64'(d), 64'h0);
      rd(8'h2C, d); chk("R7 read clr1", 64'(d), 64'h0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      pad_in = {22'h2ABCDE, 32'hC0FFEE11};
      repeat (3) @(negedge clk);
      rd(8'h34, d); chk("R9 level bank0", 64'(d), 64'hC0FFEE11);
      rd(8'h38, d); chk("R9 level bank1", 64'(d), 64'h002ABCDE);
      // latency: change and start back-to-back reads at the same moment
      @(negedge clk);
      pad_in[0] = 1'b0; bus_rd_en = 1'b1; bus_addr = 8'h34;
      @(negedge clk); chk("R9 edge1 old", 64'(bus_rdata), 64'hC0FFEE11);
      @(negedge clk); chk("R9 edge2 old", 64'(bus_rdata), 64'hC0FFEE11);
      @(negedge clk); chk("R9 edge3 new", 64'(bus_rdata), 64'hC0FFEE10);
      bus_rd_en = 1'b0;
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      logic [53:0] oe_before;
      logic [161:0] func_before;
      oe_before = pad_oe; func_before = pin_func;
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      chk("R11 latch untouched", 64'(pad_out), 64'(exp_out));
      chk("R11 oe untouched", 64'(pad_oe), 64'(oe_before));
      chk("R11 fields untouched", 64'(pin_func != func_before), 64'h0);
      rd(8'h18, d); chk("R11 read 0x18", 64'(d), 64'h0);
      rd(8'h3C, d); chk("R11 read 0x3C", 64'(d), 64'h0);
      rd(8'hFC, d); chk("R11 read 0xFC", 64'(d), 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_field_map();
      t_unused_bits();
      t_oe_codes();
      t_set_clear();
      t_retention();
      t_setclr_read();
      t_level();
      t_unmapped();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule